// File: doc/BRIEF.md
# Directory Coherence Controller with Sharer Tracking

This block is the central keeper of sharing state for a small set of memory blocks in a multi-core system. For every block it records one of three states: Invalid, Shared or Modified. It also keeps a bit-vector of the cores holding a copy and a pointer to the owning core. Cores send it read-for-share requests (GetS) and read-for-ownership requests (GetM). Every message it sends goes to a single destination core; it never broadcasts.

Each accepted request gets exactly one answer. That answer is either a data reply to the requestor or a forward to the current owner. A GetM to a shared block also tells the requestor how many invalidation acknowledgements to expect. The block then sends one invalidation to each other sharer, one per cycle. The acknowledgements travel from the sharers to the requestor; the directory does not collect them. While invalidations are still going out, new requests are held off.

Top module: `coh_directory`

## Requirements
- R1: After reset every block is Invalid with no sharers, `req_ready` is 1 and none of `rsp_valid`, `fwd_valid`, `inv_valid` is set.
- R2: A GetS (`req_excl`=0) to an Invalid or Shared block is answered in the cycle after acceptance with a reply to the requestor carrying `rsp_acks`=0, and the requestor becomes a sharer (state Shared).
- R3: A GetM (`req_excl`=1) to an Invalid block is answered with a reply carrying `rsp_acks`=0, and the block becomes Modified, owned by the requestor.
- R4: A GetM to a Shared block is answered with a reply whose `rsp_acks` equals the number of sharers other than the requestor. The block becomes Modified, owned by the requestor, with the sharer vector cleared.
- R5: After such a GetM, one invalidation per cycle goes to each other sharer, in ascending core index, starting in the same cycle as the reply. Each carries the block and the requestor's id in `inv_req`, and none goes to the requestor.
- R6: While invalidations remain to be sent, `req_ready` is 0 and a presented request is not accepted. It is accepted only once all the invalidations have gone out.
- R7: A GetS to a block Modified by another core is forwarded to the owner (`fwd_dst`=owner, `fwd_req`=requestor, `fwd_excl`=0). The block becomes Shared with both cores as sharers.
- R8: A GetM to a block Modified by another core is forwarded to the owner with `fwd_excl`=1, and ownership moves to the requestor.
- R9: A request from the owner of a Modified block to that block is answered with a reply with `rsp_acks`=0, and the block stays Modified with the same owner.
- R10: Each accepted request produces exactly one of a reply or a forward, never both. The state of one block is not changed by requests to another block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_excl | input | 1 | 1 = GetM, 0 = GetS |
| req_blk | input | $clog2(NBLK) | Block index |
| req_src | input | $clog2(NCORE) | Requesting core |
| rsp_valid | output | 1 | Data reply valid |
| rsp_dst | output | $clog2(NCORE) | Reply destination (requestor) |
| rsp_blk | output | $clog2(NBLK) | Reply block |
| rsp_acks | output | $clog2(NCORE+1) | Invalidation acks to expect |
| fwd_valid | output | 1 | Forward valid |
| fwd_dst | output | $clog2(NCORE) | Owner receiving the forward |
| fwd_blk | output | $clog2(NBLK) | Forwarded block |
| fwd_req | output | $clog2(NCORE) | Core to send data to |
| fwd_excl | output | 1 | Forward is for ownership |
| inv_valid | output | 1 | Invalidation valid |
| inv_dst | output | $clog2(NCORE) | Sharer to invalidate |
| inv_blk | output | $clog2(NBLK) | Invalidated block |
| inv_req | output | $clog2(NCORE) | Core to send the ack to |

## Verification
GetS requests are driven to Invalid, Shared and Modified blocks. This separates a data reply from a forward and shows whether the owner is recorded as a sharer after the downgrade. GetM requests are driven to blocks with zero, one, two and three other sharers, and with the requestor itself in the sharer set. These tell a correct acknowledgement count and invalidation order apart from counting the requestor or from skipping or reordering sharers. Owner self-requests, ownership handoffs and a request held behind a burst of invalidations show that ownership moves as it should and that the stall lasts exactly as many cycles as there are invalidations.

// File: rtl/coh_directory.sv
module coh_directory #(
  parameter int NCORE = 4,
  parameter int NBLK  = 8,
  localparam int CW = $clog2(NCORE),
  localparam int BW = $clog2(NBLK),
  localparam int AW = $clog2(NCORE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_excl,
  input  logic [BW-1:0] req_blk,
  input  logic [CW-1:0] req_src,
  output logic          rsp_valid,
  output logic [CW-1:0] rsp_dst,
  output logic [BW-1:0] rsp_blk,
  output logic [AW-1:0] rsp_acks,
  output logic          fwd_valid,
  output logic [CW-1:0] fwd_dst,
  output logic [BW-1:0] fwd_blk,
  output logic [CW-1:0] fwd_req,
  output logic          fwd_excl,
  output logic          inv_valid,
  output logic [CW-1:0] inv_dst,
  output logic [BW-1:0] inv_blk,
  output logic [CW-1:0] inv_req
);
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;

  logic [1:0]       st  [NBLK];
  logic [NCORE-1:0] shr [NBLK];
  logic [CW-1:0]    own [NBLK];
  logic [NCORE-1:0] pend;

  logic             take;
  logic [NCORE-1:0] self, others, low;
  logic [AW-1:0]    cnt;

  assign req_ready = (pend == '0);
  assign take      = req_valid && req_ready;
  assign self      = NCORE'(1) << req_src;
  assign others    = shr[req_blk] & ~self;
  assign low       = pend & (~pend + NCORE'(1));
  assign inv_valid = (pend != '0);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NCORE; i++) cnt = cnt + AW'(others[i]);
    inv_dst = '0;
    for (int i = NCORE - 1; i >= 0; i--) if (pend[i]) inv_dst = CW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        st[b]  <= ST_I;
        shr[b] <= '0;
        own[b] <= '0;
      end
      pend <= '0; rsp_valid <= 1'b0; fwd_valid <= 1'b0;
      rsp_dst <= '0; rsp_blk <= '0; rsp_acks <= '0;
      fwd_dst <= '0; fwd_blk <= '0; fwd_req <= '0; fwd_excl <= 1'b0;
      inv_blk <= '0; inv_req <= '0;
    end else begin
      rsp_valid <= 1'b0;
      fwd_valid <= 1'b0;
      pend      <= pend & ~low;
      if (take) begin
        rsp_dst  <= req_src;
        rsp_blk  <= req_blk;
        rsp_acks <= '0;
        fwd_blk  <= req_blk;
        fwd_req  <= req_src;
        fwd_dst  <= own[req_blk];
        fwd_excl <= req_excl;
        if (st[req_blk] == ST_M && own[req_blk] != req_src) begin
          fwd_valid <= 1'b1;
          if (req_excl) begin
            own[req_blk] <= req_src;
          end else begin
            st[req_blk]  <= ST_S;
            shr[req_blk] <= self | (NCORE'(1) << own[req_blk]);
          end
        end else begin
          rsp_valid <= 1'b1;
          if (st[req_blk] != ST_M) begin
            if (req_excl) begin
              st[req_blk]  <= ST_M;
              own[req_blk] <= req_src;
              shr[req_blk] <= '0;
              rsp_acks     <= cnt;
              pend         <= others;
              inv_blk      <= req_blk;
              inv_req      <= req_src;
            end else begin
              st[req_blk]  <= ST_S;
              shr[req_blk] <= shr[req_blk] | self;
            end
          end
        end
      end
    end
  end

  a_r5_inv_not_requestor: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> inv_dst != inv_req);
  a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !req_ready);
  a_r10_single_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && fwd_valid));
  a_r10_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || fwd_valid));
  a_r5_inv_from_getm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_valid) |-> $past(req_valid && req_ready && req_excl));
  a_r7_fwd_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(req_valid && req_ready));
endmodule

// File: tb/coh_directory_test.sv
module coh_directory_test;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_ready, req_excl = 0;
  logic [2:0] req_blk = 0;
  logic [1:0] req_src = 0;
  logic rsp_valid, fwd_valid, inv_valid, fwd_excl;
  logic [1:0] rsp_dst, fwd_dst, fwd_req, inv_dst, inv_req;
  logic [2:0] rsp_blk, fwd_blk, inv_blk, rsp_acks;

  coh_directory #(.NCORE(4), .NBLK(8)) uut (.*);

  int checks = 0, fails = 0;
  logic [10:0] expq[$];
  string tagq[$];
  int bst[8];
  logic [3:0] bsh[8];
  int bown[8];
  int prev_k = 0;
  bit done = 0;

  function automatic logic [10:0] mk(int kind, int dst, int blk, int aux, int ex);
    return {2'(kind), 2'(dst), 3'(blk), 3'(aux), 1'(ex)};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pop(logic [10:0] got);
    if (expq.size() == 0) chk(0, "R10 unexpected message", int'(got), -1);
    else begin
      logic [10:0] e = expq.pop_front();
      string t = tagq.pop_front();
      chk(got == e, t, int'(got), int'(e));
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rsp_valid) pop(mk(0, rsp_dst, rsp_blk, rsp_acks, 0));
    if (fwd_valid) pop(mk(1, fwd_dst, fwd_blk, fwd_req, fwd_excl));
    if (inv_valid) pop(mk(2, inv_dst, inv_blk, inv_req, 0));
  end

  task automatic send(bit ex, int blk, int src, string tag);
    int stalls = 0;
    logic [3:0] me, oth;
    int k = 0;
    req_valid = 1; req_excl = ex; req_blk = 3'(blk); req_src = 2'(src);
    while (!req_ready) begin stalls++; @(negedge clk); end
    chk(stalls == prev_k, "R6 stall cycles", stalls, prev_k);
    me = 4'(1 << src);
    prev_k = 0;
    if (bst[blk] == 2 && bown[blk] != src) begin
      expq.push_back(mk(1, bown[blk], blk, src, ex)); tagq.push_back(tag);
      if (ex) bown[blk] = src;
      else begin bst[blk] = 1; bsh[blk] = me | 4'(1 << bown[blk]); end
    end else if (bst[blk] == 2) begin
      expq.push_back(mk(0, src, blk, 0, 0)); tagq.push_back(tag);
    end else if (ex) begin
      oth = bsh[blk] & ~me;
      for (int i = 0; i < 4; i++) k += oth[i];
      expq.push_back(mk(0, src, blk, k, 0)); tagq.push_back(tag);
      for (int i = 0; i < 4; i++)
        if (oth[i]) begin expq.push_back(mk(2, i, blk, src, 0)); tagq.push_back("R5 invalidation"); end
      prev_k = k;
      bst[blk] = 2; bown[blk] = src; bsh[blk] = 0;
    end else begin
      expq.push_back(mk(0, src, blk, 0, 0)); tagq.push_back(tag);
      bst[blk] = 1; bsh[blk] = bsh[blk] | me;
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 8; b++) begin bst[b] = 0; bsh[b] = 0; bown[b] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1 ready", req_ready, 1);
    chk({rsp_valid, fwd_valid, inv_valid} == 0, "R1 outputs idle", {rsp_valid, fwd_valid, inv_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && !inv_valid, "R1 idle after reset", req_ready, 1);
    // R2 shares from Invalid and Shared
    send(0, 0, 0, "R2 GetS Invalid");
    send(0, 0, 2, "R2 GetS Shared");
    send(0, 0, 3, "R2 GetS Shared");
    // R4 requestor among sharers; R5 invs to 0 and 3; R6 next request stalls
    send(1, 0, 2, "R4 acks exclude requestor");
    // R7 downgrade of owner 2
    send(0, 0, 1, "R7 GetS forwarded to owner");
    send(1, 0, 1, "R4 single other sharer");
    // R3 and R8
    send(1, 3, 3, "R3 GetM Invalid");
    send(1, 3, 0, "R8 GetM forwarded");
    send(0, 3, 1, "R8 ownership moved");
    // R9 owner self-requests
    send(1, 5, 1, "R3 GetM Invalid");
    send(0, 5, 1, "R9 owner GetS");
    send(1, 5, 1, "R9 owner GetM");
    send(0, 5, 2, "R9 owner unchanged");
    // R5 ordering with three others; R10 other block untouched
    for (int c = 0; c < 4; c++) send(0, 7, c, "R2 fill sharers");
    send(1, 7, 0, "R4 three sharers");
    send(1, 6, 2, "R10 separate block");
    send(0, 3, 2, "R10 block 3 intact");
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, "R10 all answers seen", expq.size(), 0);
    chk(req_ready == 1 && !inv_valid, "R6 idle at end", req_ready, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule